// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It fetches a word from its instruction store, decodes it and reads two registers. It then computes a result or an address in the ALU, optionally reads or writes its data store, writes the register file and picks the next program counter, all between two rising edges. The supported set is five register-register operations (add, sub, and, or, set-less-than), add-immediate, load word, store word, branch-if-equal and an absolute jump within the current 256 MB region.

Both stores are word-indexed arrays inside the core. Reads are combinational and writes are synchronous. The instruction store is filled before reset through a load task on its module, and the data store starts empty. There is no streaming data interface. The only pins are a clock, a synchronous reset and plain debug outputs, which show the current program counter and any register write being committed in the present cycle.

Top module: `cpu_core`

## Requirements
- R1: While reset is high at a rising edge, the PC becomes 0. While reset is high, `dbg_we` is 0.
- R2: An instruction with opcode 000000 writes its result to the rd field [15:11] from sources rs [25:21] and rt [20:16]. The funct field [5:0] selects the operation: 100000 add, 100010 sub (rs minus rt), 100100 and, 100101 or, 101010 signed set-less-than (1 or 0).
- R3: Opcode 001000 writes rs plus the sign-extended immediate [15:0] into rt.
- R4: Opcode 100011 loads the data word at rs plus the sign-extended offset into rt. Opcode 101011 stores rt at that address and writes no register. The data store is indexed by address bits [31:2].
- R5: Opcode 000100 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by two. Otherwise the next PC is PC+4.
- R6: Opcode 000010 sets the next PC to {PC[31:28], instr[25:0], 2'b00}.
- R7: Register 0 always reads as zero. A write aimed at it is discarded and is not shown on `dbg_we`.
- R8: Every other instruction advances the PC by 4. The instruction store is indexed by PC[31:2].
- R9: In the cycle an instruction executes, `dbg_we`, `dbg_waddr` and `dbg_wdata` show the register write that the next rising edge commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Address of the instruction now executing |
| dbg_we | output | 1 | A register write is committed at the next edge |
| dbg_waddr | output | 5 | Destination register of that write |
| dbg_wdata | output | 32 | Value being written |

## Verification
The bench builds the core with its default store depths of 64 instruction words and 64 data words. These depths hold a 22-instruction program whose forward branch, absolute jump and final self-loop all land inside the array. The program covers a negative immediate, a load with a negative offset, a branch taken and not taken, a skipped jump shadow, and a discarded write to register 0. The register writes and the PC trace are checked against expectations that the bench derives from the encodings.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    mem_write;
    logic    load_sel;
    logic    branch;
    logic    jump;
    alu_fn_e alu_fn;
  } ctrl_t;
endpackage

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_fn = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_write = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_fn = ALU_ADD;
          FN_SUB:  ctrl.alu_fn = ALU_SUB;
          FN_AND:  ctrl.alu_fn = ALU_AND;
          FN_OR:   ctrl.alu_fn = ALU_OR;
          FN_SLT:  ctrl.alu_fn = ALU_SLT;
          default: ctrl.reg_write = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.b_is_imm  = 1'b1;
      end
      OP_LOAD: begin
        ctrl.reg_write = 1'b1;
        ctrl.b_is_imm  = 1'b1;
        ctrl.load_sel  = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ:  ctrl.branch = 1'b1;
      OP_JUMP: ctrl.jump   = 1'b1;
      default: ctrl = ctrl;
    endcase
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (fn)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_pkg::*;
#(
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RIDX-1:0] ra_a,
  input  logic [RIDX-1:0] ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [RIDX-1:0] wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs_q [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we && wa != '0) begin
      regs_q[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];
endmodule

// File: rtl/cpu_imem.sv
module cpu_imem
  import cpu_pkg::*;
#(
  parameter int WORDS = 64
) (
  input  logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] word
);
  localparam int AW = $clog2(WORDS);
  logic [XLEN-1:0] mem [WORDS];
  logic unused_addr;

  assign unused_addr = ^{addr[XLEN-1:AW+2], addr[1:0]};
  assign word = mem[addr[AW+1:2]];

  task automatic load_word(input int idx, input logic [XLEN-1:0] w);
    mem[idx] = w;
  endtask
endmodule

// File: rtl/cpu_dmem.sv
module cpu_dmem
  import cpu_pkg::*;
#(
  parameter int WORDS = 64
) (
  input  logic            clk,
  input  logic            we,
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);
  localparam int AW = $clog2(WORDS);
  logic [XLEN-1:0] mem [WORDS];
  logic unused_addr;

  assign unused_addr = ^{addr[XLEN-1:AW+2], addr[1:0]};
  assign rdata = mem[addr[AW+1:2]];

  always_ff @(posedge clk) begin
    if (we) mem[addr[AW+1:2]] <= wdata;
  end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_we,
  output logic [4:0]  dbg_waddr,
  output logic [31:0] dbg_wdata
);
  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0] instr_w, imm_sx, rs_val, rt_val, alu_b, alu_y, ld_val, wb_val;
  logic [RIDX-1:0] dst_idx;
  logic            take_br, rf_we;
  ctrl_t           ctrl;

  cpu_imem #(.WORDS(IMEM_WORDS)) u_imem (.addr(pc_q), .word(instr_w));

  cpu_ctrl u_ctrl (.opcode(instr_w[31:26]), .funct(instr_w[5:0]), .ctrl(ctrl));

  assign imm_sx  = {{(XLEN-16){instr_w[15]}}, instr_w[15:0]};
  assign dst_idx = ctrl.dst_is_rd ? instr_w[15:11] : instr_w[20:16];
  assign rf_we   = ctrl.reg_write && !rst;

  cpu_regfile u_rf (
    .clk(clk), .rst(rst),
    .ra_a(instr_w[25:21]), .ra_b(instr_w[20:16]),
    .rd_a(rs_val), .rd_b(rt_val),
    .we(rf_we), .wa(dst_idx), .wd(wb_val)
  );

  assign alu_b = ctrl.b_is_imm ? imm_sx : rt_val;

  cpu_alu u_alu (.a(rs_val), .b(alu_b), .fn(ctrl.alu_fn), .y(alu_y));

  cpu_dmem #(.WORDS(DMEM_WORDS)) u_dmem (
    .clk(clk), .we(ctrl.mem_write && !rst),
    .addr(alu_y), .wdata(rt_val), .rdata(ld_val)
  );

  assign wb_val = ctrl.load_sel ? ld_val : alu_y;

  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_q[31:28], instr_w[25:0], 2'b00};
  assign take_br    = ctrl.branch && (rs_val == rt_val);

  always_comb begin
    if (ctrl.jump)   pc_next = jmp_target;
    else if (take_br) pc_next = br_target;
    else             pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc    = pc_q;
  assign dbg_we    = rf_we && (dst_idx != '0);
  assign dbg_waddr = dst_idx;
  assign dbg_wdata = wb_val;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        we,
  input logic [4:0]  waddr
);
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00); // R8

  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |-> waddr != 5'd0); // R7

  AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (rst)
    instr[31:26] == 6'b101011 |-> !we); // R4

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    instr[31:26] == 6'b000010 |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}); // R6

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != 6'b000010 && instr[31:26] != 6'b000100) |=> pc == $past(pc) + 32'd4); // R8

  AST_RESET_IDLE: assert property (@(posedge clk) rst |-> !we); // R1
endmodule

bind cpu_core cpu_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(dbg_pc), .instr(instr_w),
  .we(dbg_we), .waddr(dbg_waddr)
);

// File: tb/sim_cpu_core.sv
module sim_cpu_core;
  localparam int TCLK = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc, dbg_wdata;
  logic        dbg_we;
  logic [4:0]  dbg_waddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit running = 1'b0;

  logic [36:0] exp_wr [$];
  logic [31:0] exp_pc [$];

  always #(TCLK/2) clk = ~clk;

  cpu_core u0 (.clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_we(dbg_we),
               .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata));

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
  endfunction

  task automatic expect_wr(input int r, input logic [31:0] v);
    exp_wr.push_back({r[4:0], v});
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: compares PC trace and register writes each cycle
  always @(negedge clk) begin
    if (running && !rst) begin
      if (exp_pc.size() > 0) begin
        logic [31:0] p;
        p = exp_pc.pop_front();
        check("R5/R6/R8 pc", dbg_pc, p);
      end
      if (dbg_we) begin
        if (exp_wr.size() > 0) begin
          logic [36:0] e;
          e = exp_wr.pop_front();
          check("R2/R3/R4/R9 waddr", {27'd0, dbg_waddr}, {27'd0, e[36:32]});
          check("R2/R3/R4/R9 wdata", dbg_wdata, e[31:0]);
        end else begin
          check("R7 unexpected write", {27'd0, dbg_waddr}, 32'hFFFF_FFFF);
        end
      end
    end
  end

  initial begin
    logic [31:0] prog [22];
    prog[0]  = enc_i(6'b001000, 0, 1, 5);        // R3 r1=5
    prog[1]  = enc_i(6'b001000, 0, 2, -3);       // R3 negative imm
    prog[2]  = enc_r(1, 2, 3, 6'b100000);        // R2 add
    prog[3]  = enc_r(1, 2, 4, 6'b100010);        // R2 sub
    prog[4]  = enc_r(1, 2, 5, 6'b100100);        // R2 and
    prog[5]  = enc_r(1, 2, 6, 6'b100101);        // R2 or
    prog[6]  = enc_r(2, 1, 7, 6'b101010);        // R2 slt true
    prog[7]  = enc_r(1, 2, 8, 6'b101010);        // R2 slt false
    prog[8]  = enc_i(6'b101011, 0, 4, 8);        // R4 sw
    prog[9]  = enc_i(6'b100011, 0, 9, 8);        // R4 lw
    prog[10] = enc_i(6'b001000, 0, 10, 16);
    prog[11] = enc_i(6'b100011, 10, 11, -8);     // R4 negative offset
    prog[12] = enc_i(6'b000100, 1, 2, 5);        // R5 not taken
    prog[13] = enc_i(6'b000100, 9, 11, 2);       // R5 taken -> word 16
    prog[14] = enc_i(6'b001000, 0, 12, 1);
    prog[15] = enc_i(6'b001000, 0, 12, 2);
    prog[16] = {6'b000010, 26'd19};              // R6 jump
    prog[17] = enc_i(6'b001000, 0, 13, 7);
    prog[18] = enc_i(6'b001000, 0, 13, 8);
    prog[19] = enc_i(6'b001000, 0, 0, 9);        // R7 write to r0
    prog[20] = enc_r(0, 1, 14, 6'b100000);       // R7 r0 reads zero
    prog[21] = enc_i(6'b000100, 0, 0, -1);       // self loop
    for (int i = 0; i < 64; i++) u0.u_imem.load_word(i, (i < 22) ? prog[i] : 32'd0);

    expect_wr(1, 32'd5);          expect_wr(2, 32'hFFFF_FFFD);
    expect_wr(3, 32'd2);          expect_wr(4, 32'd8);
    expect_wr(5, 32'd5);          expect_wr(6, 32'hFFFF_FFFD);
    expect_wr(7, 32'd1);          expect_wr(8, 32'd0);
    expect_wr(9, 32'd8);          expect_wr(10, 32'd16);
    expect_wr(11, 32'd8);         expect_wr(14, 32'd5);
    for (int i = 0; i < 14; i++) exp_pc.push_back(i * 4);
    exp_pc.push_back(32'd64); exp_pc.push_back(32'd76);
    exp_pc.push_back(32'd80); exp_pc.push_back(32'd84);
    exp_pc.push_back(32'd84);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", dbg_pc, 32'd0);
    check("R1 reset no write", {31'd0, dbg_we}, 32'd0);
    running = 1'b1;
    rst = 1'b0;

    while ((exp_pc.size() > 0 || exp_wr.size() > 0) && cycles < 200) begin
      @(posedge clk);
      cycles++;
    end
    if (cycles >= 200) check("watchdog", 32'd1, 32'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    running = 1'b0;
    check("R5 self loop pc", dbg_pc, 32'd84);
    check("R2/R3/R4 queue drained", exp_wr.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule